// File: doc/BRIEF.md
# Timer Interrupt Status Controller

This block holds the register file for a five-channel countdown timer. It also owns the interrupt side of that timer. A simple 32-bit memory-mapped bus reads and writes the configuration words, the control word and the per-channel count and compare buffers. Those values are driven out to the counter logic, which lives outside this block. The live count of each channel comes back in on an input bus and is readable at that channel's readback offset.

Each channel sends a one-cycle expire pulse. The pulse always sets the channel's status bit. It raises the channel's level interrupt line only when the channel is enabled at that moment. One register at offset 0x44 holds both halves:

- Bits [4:0] are the enables and are written directly.
- Bits [9:5] are the status bits and are cleared by writing ones to them.

An interrupt line falls only when software clears its status bit.

Top module: `tmr_irq_regs`

## Requirements
- R1: During and right after reset every stored word is 0, every interrupt line is low and the read data bus is 0.
- R2: Writes store the full 32-bit word, and the stored value shows on the matching output port the cycle after the write. The writable words are: configuration at 0x00 and 0x04, control at 0x08, count buffer n at 0x0C+0x0C*n for n<4 and 0x3C for channel 4, compare buffer n at 0x10+0x0C*n for n<4. Reads return the stored value.
- R3: Reads at 0x14+0x0C*n for n<4, and at 0x40 for channel 4, return bits [32n+31:32n] of the live count input. Writes to these offsets change nothing.
- R4: An undefined offset reads as 0, and a write to it changes no register. Undefined offsets are 0x48, 0x4C, anything from 0x50 up, and any address whose two low bits are not 00.
- R5: Read data appears on the read data bus one cycle after the read request and is 0 in every cycle that follows no read request.
- R6: A write to 0x44 loads bits [4:0] as the enables. A read of 0x44 returns the status bits in [9:5], the enables in [4:0] and zeros above.
- R7: An expire pulse on channel n sets status bit 5+n in the next cycle, whatever the enable.
- R8: Interrupt line n rises the cycle after an expire pulse only if enable n was set before that cycle. Setting the enable later never raises the line.
- R9: A write to 0x44 with bit 5+n at 1 clears status n and drops line n in the next cycle. A 0 in that bit, or clearing enable n, leaves status n and line n unchanged.
- R10: When an expire pulse and a clearing write hit channel n in the same cycle, the clear has no effect. Status n stays set, and line n is set if the channel is enabled and otherwise unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write request |
| bus_rd | input | 1 | Read request |
| bus_addr | input | 7 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| cfg_word0 | output | 32 | Configuration word 0x00 |
| cfg_word1 | output | 32 | Configuration word 0x04 |
| ctrl_word | output | 32 | Control word 0x08 |
| cnt_buf_o | output | 160 | Count buffers, channel n in bits [32n+31:32n] |
| cmp_buf_o | output | 128 | Compare buffers, channels 0..3 |
| cnt_now_i | input | 160 | Live counts from the counters, channel n in bits [32n+31:32n] |
| expire_i | input | 5 | One-cycle expiry pulse per channel |
| irq_o | output | 5 | Level interrupt line per channel |

## Verification
Two functions can fall in the same cycle: a channel's hardware expiry, and a software write to 0x44 that clears the same channel's status bit. The bench forces this collision on purpose for an enabled channel and for a disabled one. The random phase also pulses expiries while it writes random clear masks. Each outcome is judged against a bench model in which the expiry wins: the status bit remains set, and the line follows the enable held before that cycle.

// File: rtl/tmr_irq_pkg.sv
package tmr_irq_pkg;
  parameter int NUM_CH    = 5;
  parameter int DATA_W    = 32;
  parameter int ADDR_W    = 7;
  parameter int CH_W      = $clog2(NUM_CH);
  parameter int WORD_W    = ADDR_W - 2;
  // word index layout: 0,1 config, 2 control, then three words per channel
  parameter int CH_BASE   = 3;
  parameter int LAST_BASE = CH_BASE + 3 * (NUM_CH - 1);
  parameter int IRQ_WORD  = LAST_BASE + 2;

  typedef enum logic [2:0] {
    K_NONE, K_CFG, K_CTRL, K_CNTBUF, K_CMPBUF, K_CNTRD, K_IRQ
  } kind_e;

  typedef struct packed {
    kind_e           kind;
    logic [CH_W-1:0] ch;
  } sel_t;
endpackage

// File: rtl/tmr_addr_decode.sv
module tmr_addr_decode
  import tmr_irq_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  output sel_t              sel
);
  logic [WORD_W-1:0] word;
  assign word = addr[ADDR_W-1:2];

  always_comb begin
    sel.kind = K_NONE;
    sel.ch   = '0;
    if (addr[1:0] == 2'b00) begin
      if (word == WORD_W'(0) || word == WORD_W'(1)) begin
        sel.kind = K_CFG;
        sel.ch   = CH_W'(word[0]);
      end
      if (word == WORD_W'(2)) sel.kind = K_CTRL;
      for (int n = 0; n < NUM_CH - 1; n++) begin
        if (word == WORD_W'(CH_BASE + 3 * n)) begin
          sel.kind = K_CNTBUF;
          sel.ch   = CH_W'(n);
        end
        if (word == WORD_W'(CH_BASE + 3 * n + 1)) begin
          sel.kind = K_CMPBUF;
          sel.ch   = CH_W'(n);
        end
        if (word == WORD_W'(CH_BASE + 3 * n + 2)) begin
          sel.kind = K_CNTRD;
          sel.ch   = CH_W'(n);
        end
      end
      // last channel has no compare buffer
      if (word == WORD_W'(LAST_BASE)) begin
        sel.kind = K_CNTBUF;
        sel.ch   = CH_W'(NUM_CH - 1);
      end
      if (word == WORD_W'(LAST_BASE + 1)) begin
        sel.kind = K_CNTRD;
        sel.ch   = CH_W'(NUM_CH - 1);
      end
      if (word == WORD_W'(IRQ_WORD)) sel.kind = K_IRQ;
    end
  end
endmodule

// File: rtl/tmr_buf_bank.sv
module tmr_buf_bank
  import tmr_irq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         wr,
  input  sel_t                         sel,
  input  logic [DATA_W-1:0]            wdata,
  output logic [NUM_CH*DATA_W-1:0]     cnt_buf,
  output logic [(NUM_CH-1)*DATA_W-1:0] cmp_buf
);
  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_cnt
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr && sel.kind == K_CNTBUF && sel.ch == CH_W'(g)) q <= wdata;
      end
      assign cnt_buf[g*DATA_W +: DATA_W] = q;
    end
    for (g = 0; g < NUM_CH - 1; g++) begin : g_cmp
      logic [DATA_W-1:0] q;
      always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else if (wr && sel.kind == K_CMPBUF && sel.ch == CH_W'(g)) q <= wdata;
      end
      assign cmp_buf[g*DATA_W +: DATA_W] = q;
    end
  endgenerate
endmodule

// File: rtl/tmr_irq_chan.sv
module tmr_irq_chan (
  input  logic clk,
  input  logic rst,
  input  logic expire,
  input  logic reg_wr,
  input  logic en_bit,
  input  logic clr_bit,
  output logic en_q,
  output logic st_q,
  output logic irq_q
);
  logic clr_eff;
  // expiry wins over a same-cycle clear
  assign clr_eff = reg_wr & clr_bit & ~expire;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      st_q  <= 1'b0;
      irq_q <= 1'b0;
    end else begin
      if (reg_wr) en_q <= en_bit;
      if (expire) st_q <= 1'b1;
      else if (clr_eff) st_q <= 1'b0;
      if (expire && en_q) irq_q <= 1'b1;
      else if (clr_eff) irq_q <= 1'b0;
    end
  end
endmodule

// File: rtl/tmr_irq_regs.sv
module tmr_irq_regs
  import tmr_irq_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_wr,
  input  logic                         bus_rd,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [DATA_W-1:0]            bus_wdata,
  output logic [DATA_W-1:0]            bus_rdata,
  output logic [DATA_W-1:0]            cfg_word0,
  output logic [DATA_W-1:0]            cfg_word1,
  output logic [DATA_W-1:0]            ctrl_word,
  output logic [NUM_CH*DATA_W-1:0]     cnt_buf_o,
  output logic [(NUM_CH-1)*DATA_W-1:0] cmp_buf_o,
  input  logic [NUM_CH*DATA_W-1:0]     cnt_now_i,
  input  logic [NUM_CH-1:0]            expire_i,
  output logic [NUM_CH-1:0]            irq_o
);
  sel_t              sel;
  logic [NUM_CH-1:0] en_vec;
  logic [NUM_CH-1:0] st_vec;
  logic              irq_wr;
  logic [DATA_W-1:0] rd_val;

  tmr_addr_decode u_dec (.addr(bus_addr), .sel(sel));

  tmr_buf_bank u_buf (
    .clk(clk), .rst(rst), .wr(bus_wr), .sel(sel), .wdata(bus_wdata),
    .cnt_buf(cnt_buf_o), .cmp_buf(cmp_buf_o)
  );

  assign irq_wr = bus_wr && sel.kind == K_IRQ;

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_ch
      tmr_irq_chan u_ch (
        .clk(clk), .rst(rst), .expire(expire_i[g]), .reg_wr(irq_wr),
        .en_bit(bus_wdata[g]), .clr_bit(bus_wdata[NUM_CH + g]),
        .en_q(en_vec[g]), .st_q(st_vec[g]), .irq_q(irq_o[g])
      );
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_word0 <= '0;
      cfg_word1 <= '0;
      ctrl_word <= '0;
    end else if (bus_wr) begin
      if (sel.kind == K_CFG && sel.ch == '0) cfg_word0 <= bus_wdata;
      if (sel.kind == K_CFG && sel.ch != '0) cfg_word1 <= bus_wdata;
      if (sel.kind == K_CTRL) ctrl_word <= bus_wdata;
    end
  end

  always_comb begin
    rd_val = '0;
    case (sel.kind)
      K_CFG:    rd_val = (sel.ch == '0) ? cfg_word0 : cfg_word1;
      K_CTRL:   rd_val = ctrl_word;
      K_CNTBUF: rd_val = cnt_buf_o[sel.ch*DATA_W +: DATA_W];
      K_CMPBUF: rd_val = cmp_buf_o[sel.ch*DATA_W +: DATA_W];
      K_CNTRD:  rd_val = cnt_now_i[sel.ch*DATA_W +: DATA_W];
      K_IRQ:    rd_val = DATA_W'({st_vec, en_vec});
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else     bus_rdata <= bus_rd ? rd_val : '0;
  end
endmodule

// File: rtl/tmr_irq_regs_chk.sv
module tmr_irq_regs_chk
  import tmr_irq_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NUM_CH-1:0] expire_i,
  input logic [NUM_CH-1:0] irq_o,
  input logic [NUM_CH-1:0] en_vec,
  input logic [NUM_CH-1:0] st_vec
);
  localparam logic [ADDR_W-1:0] IRQ_ADDR = ADDR_W'(4 * IRQ_WORD);
  logic up_q;

  always_ff @(posedge clk) begin
    if (rst) up_q <= 1'b0;
    else     up_q <= 1'b1;
  end

  // R1
  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (irq_o == '0 && bus_rdata == '0));

  // R5
  assert_idle_rdata_R5: assert property (@(posedge clk) disable iff (rst)
    (up_q && !$past(bus_rd)) |-> bus_rdata == '0);

  genvar g;
  generate
    for (g = 0; g < NUM_CH; g++) begin : g_a
      assert_status_set_R7: assert property (@(posedge clk) disable iff (rst)
        expire_i[g] |=> st_vec[g]);
      assert_rise_needs_enable_R8: assert property (@(posedge clk) disable iff (rst)
        (up_q && $rose(irq_o[g])) |-> $past(expire_i[g] && en_vec[g]));
      assert_fall_needs_clear_R9: assert property (@(posedge clk) disable iff (rst)
        (up_q && $fell(irq_o[g])) |->
          $past(bus_wr && bus_addr == IRQ_ADDR && bus_wdata[NUM_CH + g]));
      assert_expiry_wins_R10: assert property (@(posedge clk) disable iff (rst)
        (expire_i[g] && bus_wr && bus_addr == IRQ_ADDR && bus_wdata[NUM_CH + g])
          |=> st_vec[g]);
    end
  endgenerate
endmodule

bind tmr_irq_regs tmr_irq_regs_chk u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .expire_i(expire_i),
  .irq_o(irq_o), .en_vec(en_vec), .st_vec(st_vec)
);

// File: tb/sim_tmr_irq_regs.sv
`timescale 1ns/1ps
module sim_tmr_irq_regs;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         bus_wr = 1'b0, bus_rd = 1'b0;
  logic [6:0]   bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata, cfg_word0, cfg_word1, ctrl_word;
  logic [159:0] cnt_buf_o, cnt_now_i;
  logic [127:0] cmp_buf_o;
  logic [4:0]   expire_i = '0, irq_o;

  always #4 clk = ~clk;

  tmr_irq_regs u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cfg_word0(cfg_word0),
    .cfg_word1(cfg_word1), .ctrl_word(ctrl_word), .cnt_buf_o(cnt_buf_o),
    .cmp_buf_o(cmp_buf_o), .cnt_now_i(cnt_now_i), .expire_i(expire_i), .irq_o(irq_o)
  );

  int total = 0, bad = 0;
  logic [31:0] m_cfg0, m_cfg1, m_ctrl, m_rdata;
  logic [31:0] m_cnt [5];
  logic [31:0] m_cmp [4];
  logic [31:0] m_now [5];
  logic [4:0]  m_en, m_st, m_irq;

  function automatic void chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endfunction

  function automatic logic [31:0] rd_model(logic [6:0] a);
    int w, n, k;
    if (a[1:0] != 2'b00) return 32'h0;
    w = int'(a >> 2);
    if (w == 0) return m_cfg0;
    if (w == 1) return m_cfg1;
    if (w == 2) return m_ctrl;
    if (w >= 3 && w <= 14) begin
      n = (w - 3) / 3; k = (w - 3) % 3;
      if (k == 0) return m_cnt[n];
      if (k == 1) return m_cmp[n];
      return m_now[n];
    end
    if (w == 15) return m_cnt[4];
    if (w == 16) return m_now[4];
    if (w == 17) return {22'h0, m_st, m_en};
    return 32'h0;
  endfunction

  function automatic void model_step(logic wr, logic rd, logic [6:0] a,
                                     logic [31:0] d, logic [4:0] ex);
    int w, n, k;
    logic c;
    m_rdata = rd ? rd_model(a) : 32'h0;
    for (int i = 0; i < 5; i++) begin
      c = wr && a == 7'h44 && d[5+i];
      if (ex[i]) m_st[i] = 1'b1; else if (c) m_st[i] = 1'b0;
      if (ex[i] && m_en[i]) m_irq[i] = 1'b1; else if (c && !ex[i]) m_irq[i] = 1'b0;
    end
    if (wr && a[1:0] == 2'b00) begin
      w = int'(a >> 2);
      if (w == 0) m_cfg0 = d;
      if (w == 1) m_cfg1 = d;
      if (w == 2) m_ctrl = d;
      if (w >= 3 && w <= 14) begin
        n = (w - 3) / 3; k = (w - 3) % 3;
        if (k == 0) m_cnt[n] = d;
        if (k == 1) m_cmp[n] = d;
      end
      if (w == 15) m_cnt[4] = d;
      if (w == 17) m_en = d[4:0];
    end
  endfunction

  task automatic step(string tag, logic wr, logic rd, logic [6:0] a,
                      logic [31:0] d, logic [4:0] ex);
    @(negedge clk);
    bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d; expire_i = ex;
    for (int i = 0; i < 5; i++) cnt_now_i[i*32 +: 32] = m_now[i];
    @(posedge clk); #1;
    model_step(wr, rd, a, d, ex);
    chk(tag, "irq", {27'h0, irq_o}, {27'h0, m_irq});
    chk(tag, "rdata", bus_rdata, m_rdata);
    chk(tag, "cfg0", cfg_word0, m_cfg0);
    chk(tag, "cfg1", cfg_word1, m_cfg1);
    chk(tag, "ctrl", ctrl_word, m_ctrl);
    for (int i = 0; i < 5; i++) chk(tag, "cntbuf", cnt_buf_o[i*32 +: 32], m_cnt[i]);
    for (int i = 0; i < 4; i++) chk(tag, "cmpbuf", cmp_buf_o[i*32 +: 32], m_cmp[i]);
  endtask

  task automatic wr_(string tag, logic [6:0] a, logic [31:0] d);
    step(tag, 1'b1, 1'b0, a, d, 5'h0);
  endtask
  task automatic rd_(string tag, logic [6:0] a);
    step(tag, 1'b0, 1'b1, a, 32'h0, 5'h0);
  endtask

  initial begin
    void'($urandom(32'd2024));
    m_cfg0 = 0; m_cfg1 = 0; m_ctrl = 0; m_rdata = 0; m_en = 0; m_st = 0; m_irq = 0;
    for (int i = 0; i < 5; i++) begin m_cnt[i] = 0; m_now[i] = 32'h1000 * (i + 1) + 7; end
    for (int i = 0; i < 4; i++) m_cmp[i] = 0;
    cnt_now_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1", "irq", {27'h0, irq_o}, 32'h0);
    chk("R1", "rdata", bus_rdata, 32'h0);
    chk("R1", "cfg0", cfg_word0, 32'h0);
    chk("R1", "ctrl", ctrl_word, 32'h0);
    rd_("R1", 7'h44);
    // R2: storage words
    wr_("R2", 7'h00, 32'hA5A5_0101); wr_("R2", 7'h04, 32'h0000_3210);
    wr_("R2", 7'h08, 32'hDEAD_BEEF);
    for (int n = 0; n < 4; n++) begin
      wr_("R2", 7'(12 + 12*n), 32'h1111_0000 + n);
      wr_("R2", 7'(16 + 12*n), 32'h2222_0000 + n);
    end
    wr_("R2", 7'h3C, 32'h3333_0004);
    for (int a = 0; a < 80; a += 4) rd_("R2", 7'(a));
    // R3: live counts, writes ignored
    for (int n = 0; n < 4; n++) begin
      wr_("R3", 7'(20 + 12*n), 32'hFFFF_FFFF); rd_("R3", 7'(20 + 12*n));
    end
    wr_("R3", 7'h40, 32'hFFFF_FFFF); rd_("R3", 7'h40);
    // R4: undefined offsets
    wr_("R4", 7'h48, 32'hFFFF_FFFF); rd_("R4", 7'h48);
    wr_("R4", 7'h4C, 32'h0000_03FF); rd_("R4", 7'h4C);
    wr_("R4", 7'h5C, 32'h1234_5678); rd_("R4", 7'h7C);
    wr_("R4", 7'h45, 32'h0000_001F); rd_("R4", 7'h45);
    wr_("R4", 7'h01, 32'h0BAD_0BAD); rd_("R4", 7'h00); rd_("R4", 7'h44);
    // R5: read then idle
    rd_("R5", 7'h08); step("R5", 1'b0, 1'b0, 7'h08, 32'h0, 5'h0);
    // R6: enable write and readback
    wr_("R6", 7'h44, 32'hFFFF_FC15); rd_("R6", 7'h44);
    wr_("R6", 7'h44, 32'h0000_0004); rd_("R6", 7'h44);
    // R7 / R8: expiry on disabled channel 1, enable afterwards
    step("R7", 1'b0, 1'b0, 7'h0, 32'h0, 5'b00010); rd_("R7", 7'h44);
    wr_("R8", 7'h44, 32'h0000_0006); rd_("R8", 7'h44);
    // R10: enabled ch2 expiry with same-cycle clear; disabled ch3 likewise
    step("R10", 1'b1, 1'b0, 7'h44, 32'h0000_0086, 5'b00100); rd_("R10", 7'h44);
    step("R10", 1'b1, 1'b0, 7'h44, 32'h0000_0106, 5'b01000); rd_("R10", 7'h44);
    // R9: zero bits keep, enable clear keeps, one clears
    wr_("R9", 7'h44, 32'h0000_0006);
    wr_("R9", 7'h44, 32'h0000_0000); rd_("R9", 7'h44);
    wr_("R9", 7'h44, 32'h0000_0080); rd_("R9", 7'h44);
    wr_("R9", 7'h44, 32'h0000_03E0); rd_("R9", 7'h44);
    // random phase
    for (int i = 0; i < 3000; i++) begin
      logic [6:0] a;
      logic [4:0] ex;
      int op;
      op = int'($urandom % 8);
      a = ($urandom % 10 == 0) ? 7'($urandom) :
          ((op < 3) ? 7'h44 : 7'(($urandom % 22) * 4));
      ex = ($urandom % 3 == 0) ? 5'($urandom) : 5'h0;
      if ($urandom % 50 == 0) m_now[$urandom % 5] = $urandom;
      step("RND", op < 5, op >= 3, a, $urandom, ex);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule